// File: doc/BRIEF.md
# Boot-Block Flash Command Interface

This block is the command front end of a byte-wide boot-block flash memory, built around an on-chip byte array. Every bus write is either a command byte or, directly after a setup command, a data byte. Reads come from one of three places, depending on the current read mode: the array, a two-byte identifier, or an 8-bit status register. The block supports block erase with a confirm step and single-byte program. The boot block is hardware-protected against both.

The array is divided into 32 equal units of `2**UNIT_W` bytes, so the address is `UNIT_W+5` bits wide. `UNIT_W = 12` gives the full 128 KiB part, where the top address bit is bit 16. The small default keeps elaboration light. The parameter `BOTTOM_BOOT` selects the layout. In the top-boot layout the main block is units 0–27, the data blocks are units 28 and 29, and the boot block is units 30–31. In the bottom-boot layout the boot block is units 0–1, unit 2 belongs to no erasable block, the data blocks are units 3 and 4, and the main block is units 4–31, so it overlaps the second data block. The parameter `INVERT_HI` flips the top bus address bit before any decoding, for boards that swap the two array halves.

A separate backdoor port loads the array at physical addresses.

Top module: `boot_flash_cui`

## Requirements
- R1: After reset the read mode is array read and the status register is 0x00. In array mode a read returns the byte stored at the decoded address.
- R2: The command 0x90 selects identifier read. At an even address it returns 0x89. At an odd address it returns 0x94 for top-boot and 0x95 for bottom-boot.
- R3: The command 0x70 selects status read, which returns the status register. The command 0x50 clears the status to 0x00 and returns the reads to the array.
- R4: The command 0x20 arms erase. If the next write carries 0xD0, every erasable block that contains that write's address is filled with 0xFF, the status becomes 0x80, and the mode becomes status read.
- R5: If the write after 0x20 carries any value other than 0xD0, the array and the status are left unchanged and the mode becomes status read.
- R6: In the top-boot layout:
  - an erase in units 0–27 clears units 0–27;
  - an erase in unit 28 or unit 29 clears only that unit;
  - an erase in units 30–31 clears nothing.
- R7: In the bottom-boot layout:
  - an erase in units 0–2 clears nothing;
  - an erase in unit 3 clears only unit 3;
  - an erase in units 4–31 clears units 4–31.
- R8: The command 0x40 or 0x10 arms program and latches the write's decoded address. The next write stores its data byte there when its address equals the latched one. It then sets the status to 0x80 and the mode to status read.
- R9: If the program data write's address differs from the latched address, nothing is stored, but the status still becomes 0x80 and the mode still becomes status read.
- R10: A program data write into a boot unit stores nothing (units 30–31 for top-boot, units 0–1 for bottom-boot).
- R11: With `INVERT_HI` set, the top address bit is flipped before array access, program latching, erase and boot-block decoding.
- R12: Any other command byte that arrives outside a setup state, such as 0xB0, 0xD0 or an undefined code, selects array read.
- R13: A backdoor write stores one byte per cycle at the physical array address, without inversion, and has priority over a program store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of mode, status and latched address |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | UNIT_W+5 | Bus address for reads and writes |
| bus_wdata | input | 8 | Command or data byte |
| bus_rdata | output | 8 | Read data, combinational from mode and address |
| bk_we | input | 1 | Backdoor write strobe |
| bk_addr | input | UNIT_W+5 | Backdoor physical byte address |
| bk_wdata | input | 8 | Backdoor byte |

## Verification
Two instances share one stimulus stream. One uses the top-boot layout without inversion. The other uses the bottom-boot layout with inversion. The same bus address therefore lands in different units, and a single write sequence separates the layout tables, the boot protection and the flipped bit.

Program is tried with the matched address, a neighbouring mismatched address, both setup codes, and addresses on each side of a boot boundary. Erase is tried with the confirm byte and with a wrong byte, and at addresses in the main, data, gap and boot regions. Reading back next-door bytes shows whether the erase went beyond its block or stopped short of it.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  localparam int unsigned NUNITS     = 32;
  localparam int unsigned UNIT_IDX_W = 5;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_ID     = 8'h90;
  localparam logic [7:0] OP_READ_STAT   = 8'h70;
  localparam logic [7:0] OP_CLR_STAT    = 8'h50;
  localparam logic [7:0] OP_ERASE_ARM   = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_ERASE_HOLD  = 8'hB0;
  localparam logic [7:0] OP_PROG_ARM    = 8'h40;
  localparam logic [7:0] OP_PROG_ARM_B  = 8'h10;

  localparam logic [7:0] MFR_BYTE    = 8'h89;
  localparam logic [7:0] DEV_TOPBOOT = 8'h94;
  localparam logic [7:0] DEV_BOTBOOT = 8'h95;
  localparam logic [7:0] STAT_DONE   = 8'h80;

  typedef enum logic [2:0] {
    MODE_ARRAY,
    MODE_ID,
    MODE_STATUS,
    MODE_ERASE_ARMED,
    MODE_PROG_ARMED
  } cui_mode_e;

  // Read mode chosen by a command byte taken outside the setup states.
  function automatic cui_mode_e mode_for_cmd(input logic [7:0] cmd);
    case (cmd)
      OP_READ_ID:                  return MODE_ID;
      OP_READ_STAT:                return MODE_STATUS;
      OP_ERASE_ARM:                return MODE_ERASE_ARMED;
      OP_PROG_ARM, OP_PROG_ARM_B:  return MODE_PROG_ARMED;
      OP_READ_ARRAY, OP_CLR_STAT,
      OP_ERASE_HOLD, OP_ERASE_GO:  return MODE_ARRAY;
      default:                     return MODE_ARRAY;
    endcase
  endfunction

  function automatic logic unit_is_boot(input logic [UNIT_IDX_W-1:0] u,
                                        input logic bottom);
    if (bottom) return (int'(u) < 2);
    return (int'(u) >= 30);
  endfunction

  function automatic logic [NUNITS-1:0] boot_unit_set(input logic bottom);
    logic [NUNITS-1:0] s;
    for (int x = 0; x < NUNITS; x++) s[x] = unit_is_boot(UNIT_IDX_W'(x), bottom);
    return s;
  endfunction

  // Units cleared by a confirmed erase whose address falls in unit hit.
  function automatic logic [NUNITS-1:0] erase_unit_set(input logic [UNIT_IDX_W-1:0] hit,
                                                       input logic bottom);
    logic [NUNITS-1:0] s;
    int h;
    h = int'(hit);
    for (int x = 0; x < NUNITS; x++) begin
      if (bottom)
        s[x] = ((h == 3) && (x == 3)) || ((h >= 4) && (x >= 4));
      else
        s[x] = ((h < 28) && (x < 28)) || ((x == h) && ((h == 28) || (h == 29)));
    end
    return s;
  endfunction

  function automatic logic [7:0] id_byte(input logic odd, input logic bottom);
    if (!odd) return MFR_BYTE;
    return bottom ? DEV_BOTBOOT : DEV_TOPBOOT;
  endfunction

endpackage

// File: rtl/flash_cui_decode.sv
module flash_cui_decode
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter bit          BOTTOM_BOOT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr_eff,
  input  logic [7:0]            wdata,
  output cui_mode_e             mode,
  output logic [7:0]            status,
  output logic                  prog_fire,
  output logic                  erase_fire,
  output logic [NUNITS-1:0]     erase_units
);

  cui_mode_e                 mode_q;
  logic [7:0]                status_q;
  logic [AW-1:0]             prog_addr_q;
  logic [UNIT_IDX_W-1:0]     cur_unit;
  logic                      idle_mode;

  assign cur_unit  = addr_eff[AW-1 -: UNIT_IDX_W];
  assign idle_mode = (mode_q != MODE_ERASE_ARMED) && (mode_q != MODE_PROG_ARMED);

  assign prog_fire   = we && (mode_q == MODE_PROG_ARMED) && (addr_eff == prog_addr_q)
                       && !unit_is_boot(cur_unit, BOTTOM_BOOT);
  assign erase_fire  = we && (mode_q == MODE_ERASE_ARMED) && (wdata == OP_ERASE_GO);
  assign erase_units = erase_fire ? erase_unit_set(cur_unit, BOTTOM_BOOT) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_ARRAY;
      status_q    <= 8'h00;
      prog_addr_q <= '0;
    end else if (we) begin
      case (mode_q)
        MODE_ERASE_ARMED: begin
          if (erase_fire) status_q <= STAT_DONE;
          mode_q <= MODE_STATUS;
        end
        MODE_PROG_ARMED: begin
          status_q <= STAT_DONE;
          mode_q   <= MODE_STATUS;
        end
        default: begin
          mode_q <= mode_for_cmd(wdata);
          if (wdata == OP_CLR_STAT) status_q <= 8'h00;
          if ((wdata == OP_PROG_ARM) || (wdata == OP_PROG_ARM_B)) prog_addr_q <= addr_eff;
        end
      endcase
    end
  end

  assign mode   = mode_q;
  assign status = status_q;

  // R5, R8: a setup state lasts exactly one write
  p_setup_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we && !idle_mode |=> mode_q == MODE_STATUS);

  // R8, R9: a program data write always reports done
  p_prog_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we && mode_q == MODE_PROG_ARMED |=> status_q == STAT_DONE);

  // R5: an unconfirmed erase leaves the status alone
  p_abort_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we && mode_q == MODE_ERASE_ARMED && wdata != OP_ERASE_GO |=> $stable(status_q));

  // R3: clear command
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we && idle_mode && wdata == OP_CLR_STAT |=> status_q == 8'h00 && mode_q == MODE_ARRAY);

  // R2: identifier entry
  p_id_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we && idle_mode && wdata == OP_READ_ID |=> mode_q == MODE_ID);

  // R12: a suspend byte outside setup returns the reads to the array
  p_hold_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
    we && idle_mode && wdata == OP_ERASE_HOLD |=> mode_q == MODE_ARRAY);

endmodule

// File: rtl/flash_unit_bank.sv
module flash_unit_bank #(
  parameter int unsigned UNIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              we,
  input  logic [UNIT_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [UNIT_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int unsigned DEPTH = 1 << UNIT_W;

  logic [7:0] mem [DEPTH];

  // Erase blanks the whole unit; a same-cycle byte write lands on top.
  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R4: an erase without a competing write leaves blank bytes
  p_erase_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase && !we |=> mem[$past(raddr)] == 8'hFF);

  // R8: a stored byte reads back
  p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter bit          BOTTOM_BOOT = 1'b0
) (
  input  cui_mode_e                mode,
  input  logic [7:0]               status,
  input  logic [AW-1:0]            addr_eff,
  input  logic [NUNITS-1:0][7:0]   unit_rd,
  output logic [7:0]               rdata
);

  logic [UNIT_IDX_W-1:0] sel_unit;

  assign sel_unit = addr_eff[AW-1 -: UNIT_IDX_W];

  always_comb begin
    case (mode)
      MODE_ID:     rdata = id_byte(addr_eff[0], BOTTOM_BOOT);
      MODE_STATUS: rdata = status;
      default:     rdata = unit_rd[sel_unit];
    endcase
  end

endmodule

// File: rtl/boot_flash_cui.sv
module boot_flash_cui
  import flash_cui_pkg::*;
#(
  parameter int unsigned UNIT_W      = 6,
  parameter bit          BOTTOM_BOOT = 1'b0,
  parameter bit          INVERT_HI   = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [UNIT_W+4:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   bk_we,
  input  logic [UNIT_W+4:0]      bk_addr,
  input  logic [7:0]             bk_wdata
);

  localparam int unsigned AW = UNIT_W + UNIT_IDX_W;
  localparam logic [AW-1:0] FLIP_MASK = {INVERT_HI, {(AW-1){1'b0}}};
  localparam logic [NUNITS-1:0] BOOT_SET = boot_unit_set(BOTTOM_BOOT);

  logic [AW-1:0]            addr_eff;
  cui_mode_e                mode;
  logic [7:0]               status;
  logic                     prog_fire;
  logic                     erase_fire;
  logic [NUNITS-1:0]        erase_units;
  logic [AW-1:0]            wsel_addr;
  logic [7:0]               wsel_data;
  logic                     wsel_en;
  logic [UNIT_IDX_W-1:0]    wsel_unit;
  logic [NUNITS-1:0]        bank_we;
  logic [NUNITS-1:0][7:0]   unit_rd;

  assign addr_eff = bus_addr ^ FLIP_MASK;

  flash_cui_decode #(.AW(AW), .BOTTOM_BOOT(BOTTOM_BOOT)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (bus_we),
    .addr_eff    (addr_eff),
    .wdata       (bus_wdata),
    .mode        (mode),
    .status      (status),
    .prog_fire   (prog_fire),
    .erase_fire  (erase_fire),
    .erase_units (erase_units)
  );

  // Backdoor wins the single array write port.
  assign wsel_addr = bk_we ? bk_addr  : addr_eff;
  assign wsel_data = bk_we ? bk_wdata : bus_wdata;
  assign wsel_en   = bk_we | prog_fire;
  assign wsel_unit = wsel_addr[AW-1 -: UNIT_IDX_W];

  for (genvar g = 0; g < NUNITS; g++) begin : g_unit
    assign bank_we[g] = wsel_en && (wsel_unit == UNIT_IDX_W'(g));
    flash_unit_bank #(.UNIT_W(UNIT_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .erase (erase_units[g]),
      .we    (bank_we[g]),
      .waddr (wsel_addr[UNIT_W-1:0]),
      .wdata (wsel_data),
      .raddr (addr_eff[UNIT_W-1:0]),
      .rdata (unit_rd[g])
    );
  end

  flash_read_path #(.AW(AW), .BOTTOM_BOOT(BOTTOM_BOOT)) u_read (
    .mode     (mode),
    .status   (status),
    .addr_eff (addr_eff),
    .unit_rd  (unit_rd),
    .rdata    (bus_rdata)
  );

  // R13, R8: at most one unit is written per cycle
  p_one_bank_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R10: only the backdoor reaches boot units
  p_boot_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we & BOOT_SET) != '0 |-> bk_we);

  // R6, R7: erase never reaches boot units
  p_boot_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |-> (erase_units & BOOT_SET) == '0);

  // R4: erase reports done at the next read
  p_erase_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> status == STAT_DONE && mode == MODE_STATUS);

endmodule

// File: tb/boot_flash_cui_bench.sv
`timescale 1ns/1ps
module boot_flash_cui_bench;

  localparam int UW    = 6;
  localparam int AW    = UW + 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bk_we = 1'b0;
  logic [AW-1:0] bk_addr = '0;
  logic [7:0]    bk_wdata = '0;
  logic [7:0]    rd_top, rd_bot;

  boot_flash_cui #(.UNIT_W(UW)) u_boot_flash_cui (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_top),
    .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata));

  boot_flash_cui #(.UNIT_W(UW), .BOTTOM_BOOT(1'b1), .INVERT_HI(1'b1)) u_boot_flash_cui_inv (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_bot),
    .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata));

  // Reference state; index 0 = top-boot plain, 1 = bottom-boot inverted.
  logic [7:0] mem_m [0:1][0:DEPTH-1];
  int         mode_m [0:1];   // 0 array, 1 id, 2 status, 3 erase armed, 4 program armed
  logic [7:0] st_m [0:1];
  int         pa_m [0:1];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  int         inst_q[$];
  int         addr_q[$];
  string      tag_q[$];
  event       sample_ev;

  function automatic int eff(input int k, input int a);
    return (k == 1) ? (a ^ (1 << (AW - 1))) : a;
  endfunction

  function automatic bit is_boot(input int k, input int u);
    return (k == 1) ? (u < 2) : (u > 29);
  endfunction

  function automatic bit hits(input int k, input int hit, input int u);
    if (k == 0) return (u == hit && (hit == 28 || hit == 29)) || (hit < 28 && u < 28);
    return (hit >= 4 && u >= 4) || (hit == 3 && u == 3);
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + (i >> 5) + 17) & 8'h7F);
  endfunction

  task automatic model_write(input int k, input int a, input logic [7:0] d);
    int e;
    int hu;
    e  = eff(k, a);
    hu = e >> UW;
    if (mode_m[k] == 3) begin
      if (d == 8'hD0) begin
        for (int i = 0; i < DEPTH; i++)
          if (hits(k, hu, i >> UW)) mem_m[k][i] = 8'hFF;
        st_m[k] = 8'h80;
      end
      mode_m[k] = 2;
    end else if (mode_m[k] == 4) begin
      if (e == pa_m[k] && !is_boot(k, hu)) mem_m[k][e] = d;
      st_m[k]   = 8'h80;
      mode_m[k] = 2;
    end else begin
      mode_m[k] = 0;
      if (d == 8'h90) mode_m[k] = 1;
      if (d == 8'h70) mode_m[k] = 2;
      if (d == 8'h20) mode_m[k] = 3;
      if (d == 8'h40 || d == 8'h10) begin mode_m[k] = 4; pa_m[k] = e; end
      if (d == 8'h50) st_m[k] = 8'h00;
    end
  endtask

  function automatic logic [7:0] model_read(input int k, input int a);
    int e;
    e = eff(k, a);
    if (mode_m[k] == 1) return (e % 2 == 1) ? ((k == 1) ? 8'h95 : 8'h94) : 8'h89;
    if (mode_m[k] == 2) return st_m[k];
    return mem_m[k][e];
  endfunction

  task automatic push_exp(input int k, input int a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    inst_q.push_back(k);
    addr_q.push_back(a);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    bus_addr = a[AW-1:0];
    push_exp(0, a, model_read(0, a), tag);
    push_exp(1, a, model_read(1, a), tag);
    #1 -> sample_ev;
  endtask

  task automatic rd_lit(input int a, input logic [7:0] e0, input logic [7:0] e1, input string tag);
    @(negedge clk);
    bus_addr = a[AW-1:0];
    push_exp(0, a, e0, tag);
    push_exp(1, a, e1, tag);
    #1 -> sample_ev;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    model_write(0, a, d);
    model_write(1, a, d);
    bus_addr  = a[AW-1:0];
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bk(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_m[0][a] = d;
    mem_m[1][a] = d;
    bk_addr  = a[AW-1:0];
    bk_wdata = d;
    bk_we    = 1'b1;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops expectations and compares them with the sampled outputs.
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        logic [7:0] got;
        int k;
        int a;
        string t;
        e = exp_q.pop_front();
        k = inst_q.pop_front();
        a = addr_q.pop_front();
        t = tag_q.pop_front();
        got = (k == 1) ? rd_bot : rd_top;
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s inst%0d addr %h: actual %h expected %h", t, k, a, got, e);
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      mode_m[k] = 0;
      st_m[k]   = 8'h00;
      pa_m[k]   = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R13: preload through the backdoor at physical addresses
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      mem_m[0][i] = pat(i);
      mem_m[1][i] = pat(i);
      bk_addr  = i[AW-1:0];
      bk_wdata = pat(i);
      bk_we    = 1'b1;
    end
    @(negedge clk);
    bk_we = 1'b0;

    // R1 reset state, R11 inversion on array reads
    rd(0, "R1");
    rd(12'h7FF, "R1 R11");
    rd(12'h123, "R1 R13");

    // R2 identifier codes
    wr(0, 8'h90);
    rd_lit(0, 8'h89, 8'h89, "R2");
    rd_lit(1, 8'h94, 8'h95, "R2");
    rd_lit(12'h403, 8'h94, 8'h95, "R2 R11");

    // R3 status read after reset shows 0x00 (R1)
    wr(0, 8'h70);
    rd_lit(5, 8'h00, 8'h00, "R3 R1");

    // R8 program with both setup codes
    wr(12'h0C5, 8'h40);
    wr(12'h0C5, 8'h5A);
    rd_lit(0, 8'h80, 8'h80, "R8");
    wr(0, 8'hFF);
    rd_lit(12'h0C5, 8'h5A, 8'h5A, "R8 R11");
    rd(12'h4C5, "R11");
    wr(12'h0C6, 8'h10);
    wr(12'h0C6, 8'hA5);
    wr(0, 8'hFF);
    rd_lit(12'h0C6, 8'hA5, 8'hA5, "R8");

    // R9 mismatched program address
    wr(12'h100, 8'h40);
    wr(12'h101, 8'h33);
    rd_lit(2, 8'h80, 8'h80, "R9");
    wr(0, 8'hFF);
    rd(12'h101, "R9");
    rd(12'h100, "R9");

    // R3 clear returns reads to the array
    wr(0, 8'h50);
    rd(12'h101, "R3");
    wr(0, 8'h70);
    rd_lit(0, 8'h00, 8'h00, "R3");

    // R10 boot protection at both boundaries
    wr(12'h7C0, 8'h40); wr(12'h7C0, 8'h66); wr(0, 8'hFF);
    rd(12'h7C0, "R10");
    wr(12'h780, 8'h40); wr(12'h780, 8'h12); wr(0, 8'hFF);
    rd(12'h780, "R10");
    wr(12'h77F, 8'h40); wr(12'h77F, 8'h21); wr(0, 8'hFF);
    rd(12'h77F, "R10");
    wr(12'h440, 8'h40); wr(12'h440, 8'h77); wr(0, 8'hFF);
    rd(12'h440, "R10 R11");

    // R5 unconfirmed erase
    wr(0, 8'h50);
    wr(12'h200, 8'h20);
    wr(12'h200, 8'h55);
    rd_lit(0, 8'h00, 8'h00, "R5");
    wr(0, 8'hFF);
    rd(12'h200, "R5");

    // R4, R6, R7 confirmed erases in several regions
    wr(12'h700, 8'h20);
    wr(12'h700, 8'hD0);
    rd_lit(0, 8'h80, 8'h80, "R4");
    wr(0, 8'hFF);
    rd_lit(12'h700, 8'hFF, 8'hFF, "R4 R6");
    rd(12'h73F, "R6");
    rd(12'h6FF, "R6 R7");
    rd(12'h740, "R6");
    wr(12'h4C0, 8'h20);
    wr(12'h4C0, 8'hD0);
    wr(0, 8'hFF);
    rd(12'h000, "R6");
    rd(12'h0C0, "R7");
    rd(12'h480, "R7");
    rd(12'h440, "R7");
    rd(12'h7C0, "R6");
    wr(12'h480, 8'h20);
    wr(12'h480, 8'hD0);
    rd_lit(0, 8'h80, 8'h80, "R7");
    wr(0, 8'hFF);
    rd(12'h480, "R7");
    wr(12'h7C0, 8'h20);
    wr(12'h7C0, 8'hD0);
    wr(0, 8'hFF);
    rd(12'h7C0, "R6");
    rd(12'h7FF, "R6");

    // R12 stray command bytes read the array
    wr(0, 8'hB0);
    rd(12'h7FE, "R12");
    wr(0, 8'hD0);
    rd(12'h7FD, "R12");
    wr(0, 8'h33);
    rd(12'h0C5, "R12");

    // R13 backdoor ignores inversion
    bk(12'h7FF, 8'h5C);
    rd(12'h7FF, "R13");
    rd(12'h3FF, "R13");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule